// File: doc/BRIEF.md
# Lane-Packed Ramp Pattern Generator

This block emits a deterministic count pattern on a valid/ready stream so that a sink further down the chip can check every bit of every word it receives. Each output beat is a wide word cut into 16-bit lanes. The lanes of one beat hold consecutive count values: the lowest lane holds a running base, and each higher lane holds one more than the lane below it. Every time a beat is accepted, the base moves forward by the number of lanes. As a result, the lanes of successive beats together form one unbroken 16-bit count that wraps around.

A transfer begins with a one-cycle start pulse. At that pulse the block samples a length given in beats, clears the base to zero and raises valid. It counts accepted beats and flags the final one with last. After the final beat is accepted, valid drops and a done pulse marks the end. A start pulse that arrives while a transfer is in progress has no effect.

Top module: `lane_ramp_gen`

## Requirements
- R1: After reset, busy, done, outValid and outLast are all low.
- R2: While outValid is high, lane i of outData (bits [16*i+15:16*i], with lane 0 in bits [15:0]) equals lane 0 plus i, modulo 2^16.
- R3: A start pulse seen while idle raises outValid and busy in the next cycle, and the first beat's lane 0 value is 0.
- R4: The base advances by the lane count only on a cycle where outValid and outReady are both high. While outReady is low, outData and outValid hold steady.
- R5: Exactly lenBeats beats are accepted per transfer, and outLast is high on the final beat and on no other beat.
- R6: In the cycle after the final beat is accepted, outValid and busy are low and done is high for exactly one cycle.
- R7: A start pulse while busy is ignored. The count continues, and the transfer ends after the original length.
- R8: A start with lenBeats equal to 0 emits no beat, and done is high in the next cycle.
- R9: Lane values wrap modulo 2^16 across a long transfer.
- R10: lenBeats is sampled only at an accepted start. Changing it during a transfer does not alter the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin a transfer |
| lenBeats | input | LEN_WIDTH | Number of beats to emit, sampled at start |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse after a transfer ends |
| outData | output | BEAT_WIDTH | Lane-packed count beat |
| outValid | output | 1 | Beat on outData is valid |
| outReady | input | 1 | Sink accepts the beat this cycle |
| outLast | output | 1 | Current beat is the final beat of the transfer |

## Verification
The bench runs transfers under irregular ready patterns. A design that advanced the base on valid alone, rather than on the handshake, would show skipped count values after a stall. A second start pulse is issued in the middle of a transfer together with a new length. A design that honoured it would restart the count at zero or end after the wrong number of beats. A zero-length start checks that no beat leaks out and that done still fires. A transfer longer than 16384 four-lane beats crosses the 16-bit wrap, which exposes any lane arithmetic that is carried wider than 16 bits.

// File: rtl/lane_ramp_pkg.sv
package lane_ramp_pkg;

  localparam int LANE_BITS = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rampState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearBase;
    logic advance;
  } rampStrobe_t;

endpackage

// File: rtl/lane_ramp_ctrl.sv
module lane_ramp_ctrl
  import lane_ramp_pkg::*;
#(
  parameter int LEN_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic [LEN_WIDTH-1:0] lenBeats,
  input  logic                 outReady,
  output logic                 outValid,
  output logic                 outLast,
  output logic                 busy,
  output logic                 done,
  output rampStrobe_t          strobes
);

  rampState_t           state;
  logic [LEN_WIDTH-1:0] beatsLeft;
  logic                 accept;
  logic                 startOk;
  logic                 finalBeat;

  always_comb begin
    busy      = (state == ST_RUN);
    done      = (state == ST_DONE);
    outValid  = busy;
    finalBeat = (beatsLeft == LEN_WIDTH'(1));
    outLast   = outValid && finalBeat;
    accept    = outValid && outReady;
    startOk   = startPulse && (state != ST_RUN);
    strobes.clearBase = startOk;
    strobes.advance   = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (accept) begin
            beatsLeft <= beatsLeft - LEN_WIDTH'(1);
            if (finalBeat) state <= ST_DONE;
          end
        end
        default: begin
          if (startOk) begin
            beatsLeft <= lenBeats;
            state     <= (lenBeats == '0) ? ST_DONE : ST_RUN;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lane_ramp_datapath.sv
module lane_ramp_datapath
  import lane_ramp_pkg::*;
#(
  parameter int BEAT_WIDTH = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rampStrobe_t           strobes,
  output logic [BEAT_WIDTH-1:0] outData
);

  localparam int LANES = BEAT_WIDTH / LANE_BITS;
  localparam logic [LANE_BITS-1:0] STEP = LANE_BITS'(LANES);

  logic [LANE_BITS-1:0] base;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
    end else if (strobes.clearBase) begin
      base <= '0;
    end else if (strobes.advance) begin
      base <= base + STEP;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign outData[i*LANE_BITS +: LANE_BITS] = base + LANE_BITS'(i);
  end

endmodule

// File: rtl/lane_ramp_gen.sv
module lane_ramp_gen
  import lane_ramp_pkg::*;
#(
  parameter int BEAT_WIDTH = 64,
  parameter int LEN_WIDTH  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [LEN_WIDTH-1:0]  lenBeats,
  output logic                  busy,
  output logic                  done,
  output logic [BEAT_WIDTH-1:0] outData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  outLast
);

  rampStrobe_t strobes;

  lane_ramp_ctrl #(.LEN_WIDTH(LEN_WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lenBeats   (lenBeats),
    .outReady   (outReady),
    .outValid   (outValid),
    .outLast    (outLast),
    .busy       (busy),
    .done       (done),
    .strobes    (strobes)
  );

  lane_ramp_datapath #(.BEAT_WIDTH(BEAT_WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .outData (outData)
  );

endmodule

// File: rtl/lane_ramp_checker.sv
module lane_ramp_checker #(
  parameter int BEAT_WIDTH = 64,
  parameter int LEN_WIDTH  = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startPulse,
  input logic [LEN_WIDTH-1:0]  lenBeats,
  input logic                  busy,
  input logic                  done,
  input logic [BEAT_WIDTH-1:0] outData,
  input logic                  outValid,
  input logic                  outReady,
  input logic                  outLast
);

  localparam int LANES = BEAT_WIDTH / 16;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !busy && !done && !outValid && !outLast);

  for (genvar i = 1; i < LANES; i++) begin : g_lane_chk
    p_lane_step_r2: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> outData[i*16 +: 16] == outData[15:0] + 16'(i));
  end

  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outData[15:0] == 16'd0);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outLast |=> outValid &&
      outData[15:0] == $past(outData[15:0]) + 16'(LANES));

  p_last_in_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_drop_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid && !busy && done);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy && startPulse && !(outReady && outLast) |=> busy &&
      outData[15:0] == $past(outData[15:0]) + (outReady ? 16'(LANES) : 16'd0));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startPulse && lenBeats == '0 |=> done && !outValid);

endmodule

bind lane_ramp_gen lane_ramp_checker #(
  .BEAT_WIDTH(BEAT_WIDTH),
  .LEN_WIDTH (LEN_WIDTH)
) u_lane_ramp_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .lenBeats   (lenBeats),
  .busy       (busy),
  .done       (done),
  .outData    (outData),
  .outValid   (outValid),
  .outReady   (outReady),
  .outLast    (outLast)
);

// File: tb/lane_ramp_gen_bench.sv
module lane_ramp_gen_bench;

  localparam int BEAT_WIDTH = 64;
  localparam int LEN_WIDTH  = 16;
  localparam int LANES      = BEAT_WIDTH / 16;
  localparam int NVEC       = 6;

  // stimulus: length, ready pattern; expected: lane 0 of the last beat
  localparam int              VEC_LEN  [NVEC] = '{1, 2, 3, 7, 12, 4};
  localparam logic [7:0]      VEC_RDY  [NVEC] = '{8'hFF, 8'h55, 8'hF0, 8'h33, 8'hB7, 8'h01};
  localparam logic [15:0]     VEC_LAST [NVEC] = '{16'd0, 16'd4, 16'd8, 16'd24, 16'd44, 16'd12};

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  startPulse = 1'b0;
  logic [LEN_WIDTH-1:0]  lenBeats = '0;
  logic                  busy, done, outValid, outReady, outLast;
  logic [BEAT_WIDTH-1:0] outData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lane_ramp_gen #(.BEAT_WIDTH(BEAT_WIDTH), .LEN_WIDTH(LEN_WIDTH)) u_lane_ramp_gen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenBeats(lenBeats),
    .busy(busy), .done(done), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1'b1;
    $finish;
  endtask

  // Runs one transfer. At beat index interruptAt a second start is pulsed
  // with a different length (R7, R10). Returns lane 0 of the last beat.
  task automatic runTransfer(input int len, input logic [7:0] rdyMask,
                             input int interruptAt, input bit perBeat,
                             output logic [15:0] lastBase, output int accepted);
    logic [15:0] expBase = 16'd0;
    int cyc = 0;
    bit firstSeen = 1'b0;
    accepted = 0;
    lastBase = 16'hFFFF;
    @(negedge clk);
    startPulse = 1'b1;
    lenBeats   = LEN_WIDTH'(len);
    @(negedge clk);
    startPulse = 1'b0;
    while (1) begin
      outReady = rdyMask[cyc % 8];
      if (!firstSeen) begin
        check(outValid && busy, "R3", "valid after start", outValid, 1);
        check(outData[15:0] == 16'd0, "R3", "first lane0", outData[15:0], 0);
        firstSeen = 1'b1;
      end
      if (!outValid) break;
      if (perBeat || accepted == 16384) begin
        for (int i = 0; i < LANES; i++) begin
          check(outData[i*16 +: 16] == 16'(expBase + 16'(i)), "R2 R4 R9", "lane value",
                outData[i*16 +: 16], 16'(expBase + 16'(i)));
        end
      end
      if (outReady) begin
        if (perBeat || accepted >= len - 1)
          check(outLast == (accepted == len - 1), "R5", "last flag", outLast,
                accepted == len - 1);
        lastBase = outData[15:0];
        if (accepted == interruptAt) begin
          startPulse = 1'b1;
          lenBeats   = LEN_WIDTH'(len + 5);
        end
        accepted++;
        expBase = expBase + 16'(LANES);
        if (outLast) begin
          @(negedge clk);
          startPulse = 1'b0;
          check(!outValid && !busy && done, "R6", "end state", {outValid, busy, done}, 3'b001);
          @(negedge clk);
          check(!done, "R6", "done one cycle", done, 0);
          break;
        end
      end
      @(negedge clk);
      startPulse = 1'b0;
      cyc++;
    end
    outReady = 1'b0;
  endtask

  initial begin
    logic [15:0] lb;
    int acc;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !outValid && !outLast, "R1", "reset outputs",
          {busy, done, outValid, outLast}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !outValid, "R1", "idle after reset", {busy, outValid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      runTransfer(VEC_LEN[v], VEC_RDY[v], -1, 1'b1, lb, acc);
      check(acc == VEC_LEN[v], "R5", "beats accepted", acc, VEC_LEN[v]);
      check(lb == VEC_LAST[v], "R4", "last beat lane0", lb, VEC_LAST[v]);
    end

    // R8: zero length
    @(negedge clk);
    startPulse = 1'b1;
    lenBeats   = '0;
    @(negedge clk);
    startPulse = 1'b0;
    check(done && !outValid && !busy, "R8", "zero length", {done, outValid, busy}, 3'b100);
    @(negedge clk);
    check(!done && !outValid, "R8", "zero length quiet", {done, outValid}, 0);

    // R7 and R10: restart attempt and new length mid-transfer
    runTransfer(6, 8'hDB, 2, 1'b1, lb, acc);
    check(acc == 6, "R7 R10", "beats after ignored start", acc, 6);
    check(lb == 16'd20, "R7", "count continued", lb, 20);

    // R9: wrap across 2^16
    runTransfer(16390, 8'hFF, -1, 1'b0, lb, acc);
    check(acc == 16390, "R9", "long run beats", acc, 16390);
    check(lb == 16'(16389 * LANES), "R9", "wrapped lane0", lb, 16'(16389 * LANES));

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule